// File: doc/BRIEF.md
# Dual Masked Alarm Comparator

This block holds two time-of-day alarms for a real-time clock and turns matches into interrupt requests. Each alarm has four byte fields (seconds, minutes, hours, day of week) held in BCD. On every one-second pulse from the timekeeping logic, each alarm compares its fields against the running time. A full match sets that alarm's pending flag. Setting the top bit of a field turns that field into a wildcard that always matches.

A host reaches the alarm fields, a control byte and a status byte through a simple register port with separate read and write strobes. Control bits enable the interrupt of each alarm and choose whether the two alarms share the first interrupt pin or use one pin each. The interrupt pins are active low and stay asserted while an enabled flag is pending. A flag clears when the host reads any field of its alarm, or when the host writes a zero to that flag's position in the status byte. The timekeeping counters and the serial framing sit outside this block.

Top module: `dual_alarm_match`

## Requirements
- R1: Alarm 0 fields are at addresses 0x07 (seconds), 0x08 (minutes), 0x09 (hours), 0x0A (day of week), and alarm 1 fields are at 0x0B to 0x0E in the same order. A written byte is returned on `reg_rdata` at the clock edge that samples the read strobe and is held until the next read.
- R2: An alarm compares only in a cycle where `sec_tick` is high; its flag becomes set at that clock edge when every field matches, and matching time without a tick sets nothing.
- R3: A field whose bit 7 is 1 matches any time value.
- R4: An unmasked field matches when its bits 6:0 equal the 7-bit time input; for the hour field this includes bit 6 (12-hour mode) and bit 5 (PM), so 0x12 does not match 0x52.
- R5: The status byte at 0x10 shows alarm 0's flag in bit 0 and alarm 1's flag in bit 1 (other bits read 0); a flag is set on a match whether or not its interrupt is enabled.
- R6: The control byte at 0x0F is read back as written; bit 0 enables alarm 0's interrupt and bit 1 enables alarm 1's interrupt. An interrupt request exists only when a flag and its enable are both 1.
- R7: With control bit 2 at 0 both alarm requests drive `irq0_n` low and `irq1_n` stays high; with control bit 2 at 1 alarm 1 drives only `irq1_n` and alarm 0 drives only `irq0_n`.
- R8: Reading any field of an alarm clears that alarm's flag and leaves the other alarm's flag unchanged.
- R9: A write to 0x10 clears each flag whose bit position is written 0 and leaves a flag whose bit is written 1; writing 0x00 clears both.
- R10: When a match and a clear of the same flag happen in one cycle, the flag ends set.
- R11: After reset all alarm fields, control and status are 0x00, `reg_rdata` is 0x00 and both interrupt pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse at each second boundary |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours, BCD with mode and PM bits |
| now_wday | input | 7 | Current day of week |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq0_n | output | 1 | Interrupt pin 0, active low |
| irq1_n | output | 1 | Interrupt pin 1, active low |

## Verification
The hardest situation to reach is a match arriving in the very cycle the host clears the same flag, since it needs a tick and a read or status write on one edge. The bench programs an all-wildcard alarm so any tick matches, then raises the tick and the read strobe of that alarm together and reads the status afterwards. Routing is exercised by moving a pending alarm 1 request between pins with only the control byte changing, with alarm 0 silent.

// File: rtl/dual_alarm_pkg.sv
// Shared constants for the dual alarm comparator.
// Assumes byte-wide registers and a 7-bit register address space.
package dual_alarm_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 7;
    localparam int TIME_W     = 7;
    localparam int NUM_FIELDS = 4;
    localparam int NUM_ALARMS = 2;
    localparam int FIELD_IDX_W = $clog2(NUM_FIELDS);

    // Address map: alarms are contiguous, four fields each.
    localparam logic [ADDR_W-1:0] ALM_BASE  = 7'h07;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h0F;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 7'h10;
    localparam int ALM_SPAN = NUM_FIELDS * NUM_ALARMS;

    // Bit positions inside fields and the control byte.
    localparam int WILD_BIT  = 7;
    localparam int ROUTE_BIT = 2;

    typedef logic [DATA_W-1:0] field_t;
    typedef logic [TIME_W-1:0] tval_t;
endpackage

// File: rtl/alarm_field_match.sv
// One alarm field compare: matches when the wildcard bit is set or the
// low seven bits equal the current time value.
// Assumes the time input is already aligned to the field's low bits.
module alarm_field_match
    import dual_alarm_pkg::*;
(
    input  field_t fld,
    input  tval_t  now_val,
    output logic   hit
);
    // Wildcard or exact equality of the value bits.
    always_comb begin
        hit = fld[WILD_BIT] || (fld[TIME_W-1:0] == now_val);
    end
endmodule

// File: rtl/alarm_unit.sv
// One alarm: four field registers, a comparator per field and the
// pending flag. A match on a tick wins over a clear in the same cycle.
// Assumes wr_en and rd_clr are already decoded for this alarm.
module alarm_unit
    import dual_alarm_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             tick,
    input  tval_t  [NUM_FIELDS-1:0]          now_vals,
    input  logic                             wr_en,
    input  logic   [FIELD_IDX_W-1:0]         wr_idx,
    input  field_t                           wr_data,
    input  logic                             rd_clr,
    input  logic                             st_clr,
    output field_t [NUM_FIELDS-1:0]          fields,
    output logic                             flag
);
    field_t [NUM_FIELDS-1:0] fld_q;
    logic   [NUM_FIELDS-1:0] hits;
    logic                    all_hit;

    // Field storage and per-field comparators.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
            // Hold the field value written by the host.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    fld_q[gi] <= '0;
                end else if (wr_en && (wr_idx == FIELD_IDX_W'(gi))) begin
                    fld_q[gi] <= wr_data;
                end
            end

            alarm_field_match u_match (
                .fld     (fld_q[gi]),
                .now_val (now_vals[gi]),
                .hit     (hits[gi])
            );
        end
    endgenerate

    // All fields must agree for the alarm to fire.
    always_comb begin
        all_hit = &hits;
    end

    // Pending flag: set on tick with match, else cleared by host action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (tick && all_hit) begin
            flag <= 1'b1;
        end else if (rd_clr || st_clr) begin
            flag <= 1'b0;
        end
    end

    assign fields = fld_q;
endmodule

// File: rtl/alarm_irq_router.sv
// Combines flags with enables and steers them onto two active-low pins.
// With the route bit clear every request lands on pin 0; with it set,
// alarm 1 moves to pin 1. Assumes exactly two alarms.
module alarm_irq_router
    import dual_alarm_pkg::*;
(
    input  logic [NUM_ALARMS-1:0] flags,
    input  logic [NUM_ALARMS-1:0] enables,
    input  logic                  route_split,
    output logic                  irq0_n,
    output logic                  irq1_n
);
    logic [NUM_ALARMS-1:0] req;

    // Gate each flag with its enable, then pick pins.
    always_comb begin
        req    = flags & enables;
        irq0_n = !(req[0] || (req[1] && !route_split));
        irq1_n = !(req[1] && route_split);
    end
endmodule

// File: rtl/dual_alarm_match.sv
// Top of the dual alarm comparator: address decode, control byte,
// registered read data, two alarm units and the interrupt router.
// Assumes sec_tick is a single-cycle pulse and the time inputs are
// stable in that cycle. Unmapped reads return zero; unmapped writes
// are dropped.
module dual_alarm_match
    import dual_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [TIME_W-1:0] now_sec,
    input  logic [TIME_W-1:0] now_min,
    input  logic [TIME_W-1:0] now_hour,
    input  logic [TIME_W-1:0] now_wday,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq0_n,
    output logic              irq1_n
);
    localparam logic [ADDR_W-1:0] ALM_LAST = ALM_BASE + ADDR_W'(ALM_SPAN - 1);

    tval_t  [NUM_FIELDS-1:0]                 now_vals;
    field_t [NUM_ALARMS-1:0][NUM_FIELDS-1:0] alm_fields;
    logic   [NUM_ALARMS-1:0]                 flag_q;
    logic   [NUM_ALARMS-1:0]                 alm_hit;
    logic   [NUM_ALARMS-1:0]                 st_clr;
    logic   [ADDR_W-1:0]                     alm_off;
    logic                                    in_alm_range;
    logic   [FIELD_IDX_W-1:0]                fld_idx;
    field_t                                  ctrl_q;
    field_t                                  rd_mux;

    // Pack the time inputs in field order: seconds, minutes, hours, day.
    always_comb begin
        now_vals[0] = now_sec;
        now_vals[1] = now_min;
        now_vals[2] = now_hour;
        now_vals[3] = now_wday;
    end

    // Decode the alarm window into alarm number and field index.
    always_comb begin
        in_alm_range = (reg_addr >= ALM_BASE) && (reg_addr <= ALM_LAST);
        alm_off      = reg_addr - ALM_BASE;
        fld_idx      = alm_off[FIELD_IDX_W-1:0];
    end

    genvar ai;
    generate
        for (ai = 0; ai < NUM_ALARMS; ai++) begin : g_alarm
            // Per-alarm select and status-write clear.
            always_comb begin
                alm_hit[ai] = in_alm_range &&
                    (alm_off[ADDR_W-1:FIELD_IDX_W] == (ADDR_W-FIELD_IDX_W)'(ai));
                st_clr[ai]  = reg_wr && (reg_addr == STAT_ADDR) && !reg_wdata[ai];
            end

            alarm_unit u_alarm (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (sec_tick),
                .now_vals (now_vals),
                .wr_en    (reg_wr && alm_hit[ai]),
                .wr_idx   (fld_idx),
                .wr_data  (reg_wdata),
                .rd_clr   (reg_rd && alm_hit[ai]),
                .st_clr   (st_clr[ai]),
                .fields   (alm_fields[ai]),
                .flag     (flag_q[ai])
            );
        end
    endgenerate

    // Control byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr && (reg_addr == CTRL_ADDR)) begin
            ctrl_q <= reg_wdata;
        end
    end

    // Select the byte the host is reading.
    always_comb begin
        rd_mux = '0;
        if (in_alm_range) begin
            for (int a = 0; a < NUM_ALARMS; a++) begin
                if (alm_hit[a]) begin
                    rd_mux = alm_fields[a][fld_idx];
                end
            end
        end else if (reg_addr == CTRL_ADDR) begin
            rd_mux = ctrl_q;
        end else if (reg_addr == STAT_ADDR) begin
            rd_mux = DATA_W'(flag_q);
        end
    end

    // Register read data on the read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

    alarm_irq_router u_router (
        .flags       (flag_q),
        .enables     (ctrl_q[NUM_ALARMS-1:0]),
        .route_split (ctrl_q[ROUTE_BIT]),
        .irq0_n      (irq0_n),
        .irq1_n      (irq1_n)
    );
endmodule

// File: rtl/dual_alarm_match_chk.sv
// Assertion checker for the dual alarm comparator, bound to the top.
// Observes the register port, the tick, the flags and the pins.
module dual_alarm_match_chk
    import dual_alarm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [1:0]        flags,
    input logic [1:0]        enables,
    input logic              route_split,
    input logic              irq0_n,
    input logic              irq1_n
);
    logic rd_alm0;
    logic zero_stat_wr;

    // Host actions that must clear alarm 0 or both flags.
    always_comb begin
        rd_alm0      = reg_rd && (reg_addr >= 7'h07) && (reg_addr <= 7'h0A);
        zero_stat_wr = reg_wr && (reg_addr == STAT_ADDR) && (reg_wdata == '0);
    end

    AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(sec_tick)); // R2

    AST_PIN1_IDLE_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        !route_split |-> irq1_n); // R7

    AST_PIN_NEEDS_ENABLED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !irq0_n |-> ((flags & enables) != 2'b00)); // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_alm0 && !sec_tick) |=> !flags[0]); // R8

    AST_STATUS_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_stat_wr && !sec_tick) |=> (flags == 2'b00)); // R9

    AST_MATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !rd_alm0 && !reg_wr) |=> flags[0]); // R10
endmodule

bind dual_alarm_match dual_alarm_match_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick    (sec_tick),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .flags       (flag_q),
    .enables     (ctrl_q[1:0]),
    .route_split (ctrl_q[2]),
    .irq0_n      (irq0_n),
    .irq1_n      (irq1_n)
);

// File: tb/dual_alarm_match_tb.sv
module dual_alarm_match_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    // {alarm sec,min,hour,wday, now sec,min,hour,wday, expected flag}
    localparam logic [64:0] VECS [NVEC] = '{
        {32'h30150802, 32'h30150802, 1'b1},  // R2 exact match
        {32'h30150802, 32'h31150802, 1'b0},  // R2 seconds differ
        {32'h80150802, 32'h47150802, 1'b1},  // R3 seconds wildcard
        {32'h80808080, 32'h12342105, 1'b1},  // R3 all wildcard
        {32'h00007280, 32'h00007203, 1'b1},  // R4 12h PM match
        {32'h00007280, 32'h00005203, 1'b0},  // R4 AM vs PM
        {32'h05102307, 32'h05102306, 1'b0},  // R2 day differs
        {32'h85102387, 32'h59102301, 1'b1},  // R3 sec and day wildcard
        {32'h00001280, 32'h00005201, 1'b0}   // R4 mode bit differs
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [6:0] now_sec = '0, now_min = '0, now_hour = '0, now_wday = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [6:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq0_n, irq1_n;
    int         n_checks = 0;
    int         n_fails = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_alarm_match u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_wday(now_wday),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq0_n(irq0_n), .irq1_n(irq1_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic tick_at(input logic [31:0] t);
        @(negedge clk);
        now_sec = t[30:24]; now_min = t[22:16]; now_hour = t[14:8]; now_wday = t[6:0];
        sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic load_alarm(input int which, input logic [31:0] f);
        wr(7'(7 + 4*which), f[31:24]);
        wr(7'(8 + 4*which), f[23:16]);
        wr(7'(9 + 4*which), f[15:8]);
        wr(7'(10 + 4*which), f[7:0]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 rdata", reg_rdata, 8'h00);
        check("R11 pins", {6'b0, irq1_n, irq0_n}, 8'h03);
        rd(7'h10, rv); check("R11 status", rv, 8'h00);
        rd(7'h0F, rv); check("R11 control", rv, 8'h00);
        rd(7'h0C, rv); check("R11 alarm1 min", rv, 8'h00);

        // R1 field placement and readback
        load_alarm(1, 32'h11223344);
        rd(7'h0B, rv); check("R1 alarm1 sec", rv, 8'h11);
        rd(7'h0E, rv); check("R1 alarm1 wday", rv, 8'h44);
        load_alarm(0, 32'h55667708);
        rd(7'h09, rv); check("R1 alarm0 hour", rv, 8'h77);
        rd(7'h0D, rv); check("R1 alarm1 hour untouched", rv, 8'h33);

        // R2/R3/R4 vector walk on alarm 0
        for (int i = 0; i < NVEC; i++) begin
            load_alarm(0, VECS[i][64:33]);
            wr(7'h10, 8'h00);
            tick_at(VECS[i][32:1]);
            rd(7'h10, rv);
            check($sformatf("R2/R3/R4 vector %0d", i), rv & 8'h01, {7'b0, VECS[i][0]});
        end

        // R2 matching time without tick sets nothing
        load_alarm(0, 32'h80808080);
        wr(7'h10, 8'h00);
        repeat (4) @(negedge clk);
        rd(7'h10, rv); check("R2 no tick", rv, 8'h00);

        // R5 flag set while interrupt disabled; R6 pin stays high
        tick_at(32'h01020304);
        check("R6 disabled pin", {7'b0, irq0_n}, 8'h01);
        rd(7'h10, rv); check("R5 flag without enable", rv, 8'h01);
        wr(7'h0F, 8'h01);
        check("R6 enabled pin low", {7'b0, irq0_n}, 8'h00);
        rd(7'h0F, rv); check("R6 control readback", rv, 8'h01);

        // R10 tick and read clear in one cycle: flag stays
        @(negedge clk); reg_rd = 1'b1; reg_addr = 7'h07; sec_tick = 1'b1;
        @(negedge clk); reg_rd = 1'b0; sec_tick = 1'b0;
        rd(7'h10, rv); check("R10 match wins", rv, 8'h01);

        // R8 read clears only own alarm
        load_alarm(1, 32'h80808080);
        tick_at(32'h00000000);
        rd(7'h10, rv); check("R5 both flags", rv, 8'h03);
        rd(7'h0C, rv);
        rd(7'h10, rv); check("R8 read alarm1 clears only it", rv, 8'h01);
        check("R8 pin0 held by alarm0", {7'b0, irq0_n}, 8'h00);
        rd(7'h08, rv);
        rd(7'h10, rv); check("R8 read alarm0", rv, 8'h00);
        check("R8 pin0 released", {7'b0, irq0_n}, 8'h01);

        // R9 selective and full status clear
        tick_at(32'h00000000);
        wr(7'h10, 8'h01);
        rd(7'h10, rv); check("R9 keep bit0 clear bit1", rv, 8'h01);
        tick_at(32'h00000000);
        wr(7'h10, 8'h00);
        rd(7'h10, rv); check("R9 write zero", rv, 8'h00);

        // R7 routing of alarm 1
        wr(7'h0F, 8'h02);
        tick_at(32'h00000000);
        wr(7'h10, 8'h02);
        check("R7 shared pin", {6'b0, irq1_n, irq0_n}, 8'h02);
        wr(7'h0F, 8'h06);
        check("R7 split pin", {6'b0, irq1_n, irq0_n}, 8'h01);
        wr(7'h0F, 8'h05);
        check("R7 split alarm1 disabled", {6'b0, irq1_n, irq0_n}, 8'h03);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule